// File: doc/BRIEF.md
# Single-Bus Memory-Add Step Controller

This block is a small processor slice in which every register exchanges data over one shared internal bus. Each register that can drive the bus has an output gate, and each register that can take a value from it has a load gate. The block also holds a word-wide memory that sits behind an address-bus gate and a data-bus gate. A sequencer opens these gates one step at a time so that the accumulator gains the contents of a memory word.

The arithmetic unit cannot reach both operands over a single bus. One operand is therefore parked in a temporary register Y. The accumulator feeds the adder directly, and the sum is caught in a second temporary register Z before it returns to the accumulator over the bus.

A pulse on `start` while the block is idle captures an address field and runs five steps:
- T1: IR address to MAR.
- T2: memory to MBR, through the address gate and the read strobe.
- T3: MBR to Y.
- T4: the adder result into Z.
- T5: Z to AC.

The controller then spends one cycle in DONE, where `done` pulses, and returns to IDLE. The sequencer states are IDLE, T1, T2, T3, T4, T5 and DONE. The transitions are:
- IDLE to T1 on `start`.
- T1 to T2 to T3 to T4 to T5 to DONE unconditionally.
- DONE to IDLE unconditionally.

While the block is idle, two side ports load the accumulator and the memory.

Top module: `sbus_add_core`

## Requirements
- R1: After reset, `acc`, `bus_q`, `abus`, `done`, `busy` and `mem_rd` are all zero.
- R2: At most one source drives the internal bus in any cycle. The source is the IR address field (zero-extended) in T1, MBR in T3 and Z in T5, and there is no source in any other state.
- R3: When no source is enabled, `bus_q` reads zero. This holds in IDLE, T2, T4 and DONE.
- R4: `mem_rd` is high only in T2, and in that step `abus` carries the captured address. In every other cycle `abus` is zero.
- R5: At the end of T5, `acc` equals (previous `acc` + memory word at the captured address) modulo 2^16, with carry-out discarded.
- R6: `done` is high for exactly one cycle, the cycle after T5, and `acc` already holds the sum in that cycle. `busy` is high from T1 through DONE, and low otherwise.
- R7: `start` is acted on only in IDLE. Asserting it while `busy` is high neither restarts the sequence nor changes the captured address.
- R8: `acc_wr` loads `acc_wdata` into AC, and `mem_wr` writes `mem_wdata` at `mem_waddr`, only while idle. While `busy` is high, both have no effect.
- R9: Sequences issued back to back accumulate, each adding to the result of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a memory-add when idle |
| op_addr | input | 8 | Address field captured into IR at launch |
| acc_wr | input | 1 | Load AC directly (idle only) |
| acc_wdata | input | 16 | Value for direct AC load |
| mem_wr | input | 1 | Write memory word (idle only) |
| mem_waddr | input | 8 | Memory write address |
| mem_wdata | input | 16 | Memory write data |
| acc | output | 16 | Accumulator contents |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress (T1 to DONE) |
| bus_q | output | 16 | Current internal bus value |
| abus | output | 8 | External address bus after its gate |
| mem_rd | output | 1 | Memory read strobe |

## Verification
The checker watches four things on every cycle:
- that no more than one bus driver is enabled;
- that an undriven bus reads zero;
- that the read strobe appears only in T2 with the address gate open;
- that `done` is a single pulse following an accumulator load, and that T1 is never re-entered while busy.

Which value sits on the bus at each step can only be shown by the directed scenarios. The same holds for the correctness of the wrapped sum, and for the absence of effect from direct loads and writes issued mid-sequence. The scenarios compare those values against a shadow memory and sums computed in the bench.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_T5,
        ST_DONE
    } step_e;

    // bus driver indices
    localparam int DRV_IRA = 0;
    localparam int DRV_MBR = 1;
    localparam int DRV_Z   = 2;
    localparam int N_DRV   = 3;

    typedef struct packed {
        logic [N_DRV-1:0] drv;
        logic             mar_ld;
        logic             abus_en;
        logic             mem_rd;
        logic             mbr_ld;
        logic             y_ld;
        logic             z_ld;
        logic             ac_ld;
        logic             busy;
        logic             done;
    } ctl_t;

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
    import sbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output step_e step_q,
    output ctl_t  ctl
);

    step_e step_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            step_q <= step_d;
        end
    end

    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE: if (start) step_d = ST_T1;
            ST_T1:   step_d = ST_T2;
            ST_T2:   step_d = ST_T3;
            ST_T3:   step_d = ST_T4;
            ST_T4:   step_d = ST_T5;
            ST_T5:   step_d = ST_DONE;
            ST_DONE: step_d = ST_IDLE;
            default: step_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (step_q)
            ST_IDLE: ;
            ST_T1: begin
                ctl.drv[DRV_IRA] = 1'b1;
                ctl.mar_ld       = 1'b1;
                ctl.busy         = 1'b1;
            end
            ST_T2: begin
                ctl.abus_en = 1'b1;
                ctl.mem_rd  = 1'b1;
                ctl.mbr_ld  = 1'b1;
                ctl.busy    = 1'b1;
            end
            ST_T3: begin
                ctl.drv[DRV_MBR] = 1'b1;
                ctl.y_ld         = 1'b1;
                ctl.busy         = 1'b1;
            end
            ST_T4: begin
                ctl.z_ld = 1'b1;
                ctl.busy = 1'b1;
            end
            ST_T5: begin
                ctl.drv[DRV_Z] = 1'b1;
                ctl.ac_ld      = 1'b1;
                ctl.busy       = 1'b1;
            end
            ST_DONE: begin
                ctl.done = 1'b1;
                ctl.busy = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = en[i] ? src[i] : '0;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | gated[i];
        end
    end

endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = rd_en ? words[raddr] : '0;

endmodule

// File: rtl/sbus_add_core.sv
module sbus_add_core
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] acc,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] bus_q,
    output logic [ADDR_W-1:0] abus,
    output logic              mem_rd
);

    step_e step_q;
    ctl_t  ctl;

    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] z_q;
    logic [DATA_W-1:0] ac_q;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] dbus;
    logic [DATA_W-1:0] alu_sum;
    logic [N_DRV-1:0]  drv_en;
    logic [N_DRV-1:0][DATA_W-1:0] drv_src;
    logic              idle;

    sbus_seq i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .step_q (step_q),
        .ctl    (ctl)
    );

    assign idle   = (step_q == ST_IDLE);
    assign drv_en = ctl.drv;

    assign drv_src[DRV_IRA] = DATA_W'(ir_addr);
    assign drv_src[DRV_MBR] = mbr;
    assign drv_src[DRV_Z]   = z_q;

    sbus_bus #(.W(DATA_W), .N(N_DRV)) i_bus (
        .en  (drv_en),
        .src (drv_src),
        .bus (bus)
    );

    assign abus = ctl.abus_en ? mar : '0;

    sbus_mem #(.DW(DATA_W), .AW(ADDR_W)) i_mem (
        .clk   (clk),
        .we    (mem_wr && idle),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .rd_en (ctl.mem_rd),
        .raddr (abus),
        .rdata (dbus)
    );

    assign alu_sum = ac_q + y_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_addr <= '0;
            mar     <= '0;
            mbr     <= '0;
            y_q     <= '0;
            z_q     <= '0;
            ac_q    <= '0;
        end else begin
            if (idle && start)  ir_addr <= op_addr;
            if (ctl.mar_ld)     mar     <= bus[ADDR_W-1:0];
            if (ctl.mbr_ld)     mbr     <= dbus;
            if (ctl.y_ld)       y_q     <= bus;
            if (ctl.z_ld)       z_q     <= alu_sum;
            if (ctl.ac_ld)      ac_q    <= bus;
            else if (idle && acc_wr) ac_q <= acc_wdata;
        end
    end

    assign acc    = ac_q;
    assign done   = ctl.done;
    assign busy   = ctl.busy;
    assign bus_q  = bus;
    assign mem_rd = ctl.mem_rd;

endmodule

// File: rtl/sbus_add_chk.sv
module sbus_add_chk
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input step_e             step,
    input logic [N_DRV-1:0]  drv,
    input logic [DATA_W-1:0] bus,
    input logic              mem_rd,
    input logic              abus_en,
    input logic              ac_ld,
    input logic              done,
    input logic              busy
);

    p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

    p_bus_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv == '0) |-> (bus == '0));

    p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (step == ST_T2 && abus_en));

    p_done_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ac_ld));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step != ST_T1));

endmodule

bind sbus_add_core sbus_add_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_q),
    .drv     (drv_en),
    .bus     (bus),
    .mem_rd  (mem_rd),
    .abus_en (ctl.abus_en),
    .ac_ld   (ctl.ac_ld),
    .done    (done),
    .busy    (busy)
);

// File: tb/test_sbus_add_core.sv
module test_sbus_add_core;

    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          acc_wr = 1'b0;
    logic [DW-1:0] acc_wdata = '0;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] acc;
    logic          done;
    logic          busy;
    logic [DW-1:0] bus_q;
    logic [AW-1:0] abus;
    logic          mem_rd;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [1 << AW];
    logic [DW-1:0] acc_model = '0;

    always #10 clk = ~clk;

    sbus_add_core i_sbus_add_core (
        .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .mem_wr(mem_wr),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .acc(acc),
        .done(done), .busy(busy), .bus_q(bus_q), .abus(abus), .mem_rd(mem_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_mem(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        mem_wr = 1'b1; mem_waddr = a; mem_wdata = v;
        @(negedge clk);
        mem_wr = 1'b0;
        shadow[a] = v;
    endtask

    task automatic load_acc(input logic [DW-1:0] v);
        @(negedge clk);
        acc_wr = 1'b1; acc_wdata = v;
        @(negedge clk);
        acc_wr = 1'b0;
        acc_model = v;
    endtask

    // full stepwise add with per-step bus checks
    task automatic run_add(input logic [AW-1:0] a);
        logic [DW-1:0] sum;
        sum = acc_model + shadow[a];
        @(negedge clk);
        start = 1'b1; op_addr = a;
        @(posedge clk); #1 start = 1'b0;
        check("R2 T1 bus=addr", bus_q, {8'h00, a});
        check("R4 T1 abus", {abus, 7'd0, mem_rd}, '0);
        check("R6 busy T1", busy, 1);
        @(posedge clk); #1;
        check("R3 T2 bus idle", bus_q, 0);
        check("R4 T2 read", {abus, 7'd0, mem_rd}, {a, 8'd1});
        @(posedge clk); #1;
        check("R2 T3 bus=mbr", bus_q, shadow[a]);
        @(posedge clk); #1;
        check("R3 T4 bus idle", bus_q, 0);
        @(posedge clk); #1;
        check("R2 T5 bus=sum", bus_q, sum);
        check("R6 no done in T5", done, 0);
        @(posedge clk); #1;
        check("R6 done pulse", done, 1);
        check("R5 acc sum", acc, sum);
        check("R3 DONE bus idle", bus_q, 0);
        @(posedge clk); #1;
        check("R6 done low", done, 0);
        check("R6 busy low", busy, 0);
        acc_model = sum;
    endtask

    task automatic t_reset;
        check("R1 acc", acc, 0);
        check("R1 outputs", {bus_q, abus, done, busy, mem_rd}, '0);
    endtask

    task automatic t_basic;
        load_mem(8'h10, 16'h1234);
        load_acc(16'h0101);
        run_add(8'h10);
    endtask

    task automatic t_overflow;
        load_mem(8'hFF, 16'hFFF0);
        load_acc(16'h0025);
        run_add(8'hFF);
        check("R5 wrapped", acc, 16'h0015);
    endtask

    task automatic t_random;
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            load_mem(a, DW'($urandom));
            load_acc(DW'($urandom));
            run_add(a);
        end
    endtask

    task automatic t_chain;
        load_mem(8'h21, 16'h4000);
        load_mem(8'h22, 16'h9001);
        load_acc(16'h0003);
        run_add(8'h21);
        run_add(8'h22);
        run_add(8'h21);
        check("R9 chained", acc, 16'h1004);
    endtask

    task automatic t_busy_ignore;
        logic [DW-1:0] sum;
        load_mem(8'h30, 16'h0200);
        load_mem(8'h31, 16'h7777);
        load_acc(16'h0011);
        sum = 16'h0211;
        @(negedge clk);
        start = 1'b1; op_addr = 8'h30;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);   // in T1: try restart with new address
        start = 1'b1; op_addr = 8'h31;
        acc_wr = 1'b1; acc_wdata = 16'hDEAD;
        mem_wr = 1'b1; mem_waddr = 8'h31; mem_wdata = 16'h5555;
        @(negedge clk);   // in T2
        @(negedge clk);   // in T3
        start = 1'b0; acc_wr = 1'b0; mem_wr = 1'b0;
        @(posedge clk); @(posedge clk); @(posedge clk); #1;
        check("R7 done at normal time", done, 1);
        check("R7 R8 acc unaffected", acc, sum);
        @(posedge clk); #1;
        check("R7 no restart", busy, 0);
        acc_model = sum;
        run_add(8'h31);
        check("R8 mem write ignored", acc, 16'h7988);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
        #1 t_reset;
        #30 rst_n = 1'b1;
        t_basic;
        t_overflow;
        t_random;
        t_chain;
        t_busy_ignore;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule